// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block drives a serial peripheral bus as its master. Software loads one word at a time through a simple register write port. The word waits in a single holding register until the shift register is free, then moves into the shifter and goes out on SDO, most significant bit first. At the same time, one bit per pulse is captured from SDI. When the last pulse of a word has finished, the captured word is moved into a receive buffer, which software reads back through the read port.

A programmable divider sets the serial clock, and that clock runs only while a word is in the shifter. The idle level of the clock, the edge on which data changes, and a word size of 8, 16 or 32 bits are all configurable. Configuration is expected to change only while the block is idle. The holding register lets software queue the next word while the current one is shifting, so consecutive words go out with no gap between them.

Status outputs report transmit-empty, transmit-full, receive-full, receive-overflow and a sticky completion flag. Clearing the enable input stops everything and returns the block to its reset state.

Top module: `spiBufMaster`

## Requirements
- R1: Each half period of `sck` lasts `divisor`+1 clock cycles, so the serial clock runs at the system clock divided by 2×(`divisor`+1). `divisor` is 9 bits wide, and the value 511 is supported.
- R2: `wordSel` sets the word length: 0 selects 8 bits, 1 selects 16, and 2 or 3 select 32. Each word gets exactly that many `sck` pulses. Data leaves on `sdo` MSB first. The bits captured from `sdi` (first bit = MSB) appear right-aligned on `rdData`, with the upper bits at zero.
- R3: When no word is shifting, `sck` rests at the `cpol` level (1 = idle high). It toggles only while a word is in the shifter.
- R4: With `edgeSel`=1, `sdo` changes on the active-to-idle transition and the first bit is valid before the first pulse; `sdi` is sampled on idle-to-active. With `edgeSel`=0, `sdo` changes on idle-to-active and `sdi` is sampled on active-to-idle.
- R5: A write accepted into an empty holding register drives `txEmpty` low and `txFull` high for the following cycle. Moving the word into the shifter sets `txEmpty` and clears `txFull`. A write while `txFull` is high is ignored.
- R6: If a word is held when the current word ends, the next word's first pulse starts exactly `divisor`+1 cycles after the previous word's last pulse has finished.
- R7: A completed word sets `rxFull` and `doneIrq`. `doneIrq` stays high until a `clrIrq` pulse.
- R8: A one-cycle `rdEn` pulse clears `rxFull`.
- R9: If `rxFull` is still high when a word completes, `rxOverflow` is set and the new word is dropped: `rdData` keeps the earlier word. `rxOverflow` stays set until a `clrOvf` pulse.
- R10: While `enable` is low, `sck` is held at idle, any transfer is stopped, the holding register is emptied, all flags are cleared (`txEmpty`=1), and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low clears and stops everything |
| cpol | input | 1 | Idle level of `sck` |
| edgeSel | input | 1 | 1: data changes on active-to-idle; 0: data changes on idle-to-active |
| wordSel | input | 2 | Word length select (0: 8, 1: 16, 2/3: 32) |
| divisor | input | 9 | Half-period length minus one, in clock cycles |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 32 | Word to transmit, right-aligned |
| rdEn | input | 1 | Read strobe; clears `rxFull` |
| rdData | output | 32 | Receive buffer, right-aligned |
| clrOvf | input | 1 | Clears `rxOverflow` |
| clrIrq | input | 1 | Clears `doneIrq` |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| txEmpty | output | 1 | Holding register empty |
| txFull | output | 1 | Holding register occupied |
| rxFull | output | 1 | Receive buffer holds an unread word |
| rxOverflow | output | 1 | A completed word was dropped |
| doneIrq | output | 1 | Sticky word-complete flag |

## Verification
A bus model acting as the slave follows `sck` in all four combinations of idle level and edge select. The driver sends a word on `sdi` with the opposite phase, and both directions are compared. A design that samples on the wrong edge produces shifted or off-by-one words.

The model also times every word. This catches a divider off by one cycle, a wrong pulse count, and any pause between queued words, which would show up as an extra half period in the gap.

Further tests target specific failure modes:
- An overflow run with no read between two words catches a design that overwrites the unread word or fails to set the flag.
- A write while the holding register is full catches a design that lets the third word replace the held one.
- Dropping `enable` mid-word catches a clock left stuck high, stale flags, and a transfer that resumes after re-enable.

// File: rtl/spiBufPkg.sv
package spiBufPkg;

  typedef enum logic [1:0] {
    LEN_8   = 2'd0,
    LEN_16  = 2'd1,
    LEN_32  = 2'd2,
    LEN_32B = 2'd3
  } wordLen_e;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic take;    // capture a software write into the holding register
    logic load;    // move holding register into the shifter
    logic emit;    // present the next transmit bit on the output
    logic sample;  // shift one received bit in
    logic commit;  // copy the received word into the receive buffer
    logic clear;   // block disabled: wipe everything
  } spiStrobe_t;

  function automatic int unsigned bitsFor(input logic [1:0] sel);
    case (wordLen_e'(sel))
      LEN_8:   return 8;
      LEN_16:  return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/spiBufCtrl.sv
module spiBufCtrl
  import spiBufPkg::*;
#(
  parameter int BRG_W  = 9,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             edgeSel,
  input  logic [1:0]       wordSel,
  input  logic [BRG_W-1:0] divisor,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             clrOvf,
  input  logic             clrIrq,
  output spiStrobe_t       strobe,
  output logic             sckActive,
  output logic             busy,
  output logic             holdFull,
  output logic             rxFull,
  output logic             rxOverflow,
  output logic             doneIrq
);

  localparam int CNT_W = $clog2(WORD_W) + 1;

  logic [BRG_W-1:0] divCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic             halfTick;
  logic             leadEdge;
  logic             trailEdge;
  logic             lastTrail;
  logic             loadNow;
  logic             takeWr;
  logic             acceptRx;
  logic             lostRx;

  always_comb begin
    halfTick  = busy && (divCnt == divisor);
    leadEdge  = halfTick && !sckActive;
    trailEdge = halfTick && sckActive;
    lastTrail = trailEdge && (bitsLeft == CNT_W'(1));
    loadNow   = enable && holdFull && (!busy || lastTrail);
    takeWr    = enable && wrEn && !holdFull;
    acceptRx  = enable && lastTrail && (!rxFull || rdEn);
    lostRx    = enable && lastTrail && rxFull && !rdEn;
  end

  always_comb begin
    strobe.take   = takeWr;
    strobe.load   = loadNow;
    strobe.sample = enable && (edgeSel ? leadEdge : trailEdge);
    if (edgeSel)
      strobe.emit = enable && (loadNow || (trailEdge && !lastTrail));
    else
      strobe.emit = enable && leadEdge;
    strobe.commit = acceptRx;
    strobe.clear  = !enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      divCnt     <= '0;
      bitsLeft   <= '0;
      sckActive  <= 1'b0;
      holdFull   <= 1'b0;
      rxFull     <= 1'b0;
      rxOverflow <= 1'b0;
      doneIrq    <= 1'b0;
    end else if (!enable) begin
      busy       <= 1'b0;
      divCnt     <= '0;
      bitsLeft   <= '0;
      sckActive  <= 1'b0;
      holdFull   <= 1'b0;
      rxFull     <= 1'b0;
      rxOverflow <= 1'b0;
      doneIrq    <= 1'b0;
    end else begin
      // divider restarts on every half period and on every load
      if (!busy || halfTick || loadNow) divCnt <= '0;
      else                              divCnt <= divCnt + BRG_W'(1);

      if (halfTick) sckActive <= !sckActive;

      if (loadNow)        busy <= 1'b1;
      else if (lastTrail) busy <= 1'b0;

      if (loadNow)        bitsLeft <= CNT_W'(bitsFor(wordSel));
      else if (trailEdge) bitsLeft <= bitsLeft - CNT_W'(1);

      if (loadNow)     holdFull <= 1'b0;
      else if (takeWr) holdFull <= 1'b1;

      if (acceptRx)  rxFull <= 1'b1;
      else if (rdEn) rxFull <= 1'b0;

      if (lostRx)      rxOverflow <= 1'b1;
      else if (clrOvf) rxOverflow <= 1'b0;

      if (lastTrail)   doneIrq <= 1'b1;
      else if (clrIrq) doneIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/spiBufData.sv
module spiBufData
  import spiBufPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic [1:0]        wordSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] rdData
);

  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] txHold;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] rxBuf;
  logic [WORD_W-1:0] aligned;
  logic [WORD_W-1:0] rxFinal;
  logic              outBit;

  // Left-align the held word so the outgoing bit is always at the top.
  always_comb begin
    aligned = txHold << (WORD_W - int'(bitsFor(wordSel)));
    rxFinal = strobe.sample ? {rxShift[MSB-1:0], sdi} : rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxBuf   <= '0;
      outBit  <= 1'b0;
    end else if (strobe.clear) begin
      txHold  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxBuf   <= '0;
      outBit  <= 1'b0;
    end else begin
      if (strobe.take) txHold <= wrData;

      if (strobe.load) begin
        if (strobe.emit) begin
          outBit  <= aligned[MSB];
          txShift <= aligned << 1;
        end else begin
          txShift <= aligned;
        end
      end else if (strobe.emit) begin
        outBit  <= txShift[MSB];
        txShift <= txShift << 1;
      end

      if (strobe.load)        rxShift <= '0;
      else if (strobe.sample) rxShift <= rxFinal;

      if (strobe.commit) rxBuf <= rxFinal;
    end
  end

  assign sdo    = outBit;
  assign rdData = rxBuf;

endmodule

// File: rtl/spiBufMaster.sv
module spiBufMaster
  import spiBufPkg::*;
#(
  parameter int BRG_W  = 9,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cpol,
  input  logic              edgeSel,
  input  logic [1:0]        wordSel,
  input  logic [BRG_W-1:0]  divisor,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  input  logic              clrOvf,
  input  logic              clrIrq,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi,
  output logic              txEmpty,
  output logic              txFull,
  output logic              rxFull,
  output logic              rxOverflow,
  output logic              doneIrq
);

  spiStrobe_t strobe;
  logic       sckActive;
  logic       shiftBusy;
  logic       holdFull;

  spiBufCtrl #(.BRG_W(BRG_W), .WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .edgeSel    (edgeSel),
    .wordSel    (wordSel),
    .divisor    (divisor),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .clrOvf     (clrOvf),
    .clrIrq     (clrIrq),
    .strobe     (strobe),
    .sckActive  (sckActive),
    .busy       (shiftBusy),
    .holdFull   (holdFull),
    .rxFull     (rxFull),
    .rxOverflow (rxOverflow),
    .doneIrq    (doneIrq)
  );

  spiBufData #(.WORD_W(WORD_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wordSel (wordSel),
    .wrData  (wrData),
    .sdi     (sdi),
    .sdo     (sdo),
    .rdData  (rdData)
  );

  assign sck     = sckActive ^ cpol;
  assign txEmpty = !holdFull;
  assign txFull  = holdFull;

endmodule

// File: rtl/spiBufChecker.sv
module spiBufChecker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic cpol,
  input logic wrEn,
  input logic clrOvf,
  input logic clrIrq,
  input logic sck,
  input logic busy,
  input logic txEmpty,
  input logic txFull,
  input logic rxFull,
  input logic rxOverflow,
  input logic doneIrq
);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sck == cpol); // R3

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    enable && wrEn && txEmpty |=> txFull); // R5

  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    enable && txFull && !busy |=> txEmpty && busy); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    enable && doneIrq && !clrIrq |=> doneIrq); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    enable && rxOverflow && !clrOvf |=> rxOverflow); // R9

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> txEmpty && !rxFull && !rxOverflow && !doneIrq && !busy); // R10

endmodule

bind spiBufMaster spiBufChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .cpol       (cpol),
  .wrEn       (wrEn),
  .clrOvf     (clrOvf),
  .clrIrq     (clrIrq),
  .sck        (sck),
  .busy       (shiftBusy),
  .txEmpty    (txEmpty),
  .txFull     (txFull),
  .rxFull     (rxFull),
  .rxOverflow (rxOverflow),
  .doneIrq    (doneIrq)
);

// File: tb/test_spiBufMaster.sv
`timescale 1ns/1ps
module test_spiBufMaster;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cpol = 1'b0;
  logic        edgeSel = 1'b0;
  logic [1:0]  wordSel = 2'd0;
  logic [8:0]  divisor = 9'd0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        clrOvf = 1'b0;
  logic        clrIrq = 1'b0;
  logic        sck;
  logic        sdo;
  logic        sdi = 1'b0;
  logic        txEmpty, txFull, rxFull, rxOverflow, doneIrq;

  always #2 clk = ~clk;

  spiBufMaster i_spiBufMaster (
    .clk(clk), .rstN(rstN), .enable(enable), .cpol(cpol), .edgeSel(edgeSel),
    .wordSel(wordSel), .divisor(divisor), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .clrOvf(clrOvf), .clrIrq(clrIrq),
    .sck(sck), .sdo(sdo), .sdi(sdi), .txEmpty(txEmpty), .txFull(txFull),
    .rxFull(rxFull), .rxOverflow(rxOverflow), .doneIrq(doneIrq)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [31:0] expQ[$];    // words the slave must see on sdo
  logic [31:0] rxExpQ[$];  // words the design must return on rdData

  int          curLen = 8;
  bit          cfgHold = 1;
  int          pulses = 0;
  int          wordIdx = 0;
  logic [31:0] mosiCap = '0;
  logic [31:0] mw = '0;
  longint      tStart[0:63];
  longint      tEnd[0:63];
  longint      curStart = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskLen(input logic [31:0] w, input int len);
    if (len >= 32) return w;
    return w & ((32'h1 << len) - 32'h1);
  endfunction

  function automatic logic [31:0] misoWord(input int idx, input int len);
    logic [31:0] w;
    w = (32'h9E3779B9 * 32'(idx + 1)) ^ 32'h5A5A0F0F;
    return maskLen(w, len);
  endfunction

  // Slave model / monitor: follows sck, answers on sdi, captures sdo.
  always @(sck) begin
    if (rstN && !cfgHold && enable) begin
      if (sck != cpol) begin
        if (pulses == 0) curStart = $time;
        pulses++;
        if (edgeSel) mosiCap = {mosiCap[30:0], sdo};
        else         sdi = mw[curLen - pulses];
      end else begin
        if (!edgeSel) mosiCap = {mosiCap[30:0], sdo};
        if (pulses == curLen) begin
          logic [31:0] e;
          check(($time - curStart) == longint'((2*curLen - 1) * (int'(divisor) + 1) * 4),
                "R1 word duration", 32'($time - curStart),
                32'((2*curLen - 1) * (int'(divisor) + 1) * 4));
          if (expQ.size() == 0) begin
            check(0, "R3 unexpected word", mosiCap, 32'h0);
          end else begin
            e = expQ.pop_front();
            check(mosiCap == maskLen(e, curLen), "R2 R4 sdo word", mosiCap,
                  maskLen(e, curLen));
          end
          rxExpQ.push_back(mw);
          if (wordIdx < 64) begin
            tStart[wordIdx] = curStart;
            tEnd[wordIdx]   = $time;
          end
          wordIdx++;
          pulses  = 0;
          mosiCap = '0;
          mw      = misoWord(wordIdx, curLen);
          if (edgeSel) sdi = mw[curLen - 1];
        end else if (edgeSel) begin
          sdi = mw[curLen - 1 - pulses];
        end
      end
    end
  end

  task automatic setup(input logic c, input logic e, input logic [1:0] s,
                       input logic [8:0] d);
    @(negedge clk);
    cfgHold = 1;
    cpol = c; edgeSel = e; wordSel = s; divisor = d;
    curLen = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    mw = misoWord(wordIdx, curLen);
    if (e) sdi = mw[curLen - 1];
    @(negedge clk);
    cfgHold = 0;
  endtask

  task automatic writeWord(input logic [31:0] w, input bit expectTaken);
    @(negedge clk);
    wrData = w; wrEn = 1'b1;
    if (expectTaken) expQ.push_back(w);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readRx(input string tag);
    logic [31:0] e;
    while (!rxFull) @(negedge clk);
    e = rxExpQ.pop_front();
    check(rdData == e, tag, rdData, e);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(!rxFull, "R8 rxFull cleared by read", 32'(rxFull), 32'h0);
  endtask

  task automatic waitWords(input int n);
    while (wordIdx < n) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int i;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txEmpty && !txFull && !rxFull && !rxOverflow && !doneIrq && sck == 1'b0,
          "R10 reset state", {27'b0, txEmpty, txFull, rxFull, rxOverflow, doneIrq},
          32'h10);
    enable = 1'b1;

    // mode: idle low, change on leading edge, 8 bits
    setup(1'b0, 1'b0, 2'd0, 9'd1);
    check(sck == 1'b0, "R3 idle low", 32'(sck), 32'h0);
    writeWord(32'hFFFF_FFA7, 1);
    check(txFull && !txEmpty, "R5 write fills holding", {txFull, txEmpty}, 2'b10);
    @(negedge clk);
    check(txEmpty && !txFull, "R5 load empties holding", {txFull, txEmpty}, 2'b01);
    readRx("R2 rx 8-bit word");
    check(doneIrq, "R7 irq set", 32'(doneIrq), 32'h1);
    repeat (5) @(negedge clk);
    check(doneIrq, "R7 irq sticky", 32'(doneIrq), 32'h1);
    clrIrq = 1'b1; @(negedge clk); clrIrq = 1'b0;
    check(!doneIrq, "R7 irq cleared", 32'(doneIrq), 32'h0);

    // mode: idle high, change on trailing edge, 16 bits
    setup(1'b1, 1'b1, 2'd1, 9'd3);
    check(sck == 1'b1, "R3 idle high", 32'(sck), 32'h1);
    writeWord(32'h0000_C35A, 1);
    readRx("R4 rx 16-bit word");

    // back-to-back, idle low, trailing-edge change, 32 bits, fastest clock
    setup(1'b0, 1'b1, 2'd2, 9'd0);
    i = wordIdx;
    writeWord(32'h8123_4567, 1);
    writeWord(32'hF00D_BEEF, 1);
    check(txFull, "R5 full while shifting", 32'(txFull), 32'h1);
    writeWord(32'h1111_1111, 0);
    readRx("R6 first queued word");
    readRx("R6 second queued word");
    check((tStart[i+1] - tEnd[i]) == 64'd4, "R6 no gap between words",
          32'(tStart[i+1] - tEnd[i]), 32'd4);
    repeat (200) @(negedge clk);
    check(wordIdx == i + 2, "R5 write while full ignored", 32'(wordIdx), 32'(i + 2));
    check(sck == 1'b0 && txEmpty, "R3 clock stops after queue drains",
          {sck, txEmpty}, 2'b01);

    // overflow: idle high, leading-edge change, 8 bits
    setup(1'b1, 1'b0, 2'd0, 9'd2);
    i = wordIdx;
    writeWord(32'h0000_003C, 1);
    waitWords(i + 1);
    check(rxFull && !rxOverflow, "R9 first word no overflow", {rxFull, rxOverflow}, 2'b10);
    writeWord(32'h0000_00C3, 1);
    waitWords(i + 2);
    check(rxOverflow, "R9 overflow set", 32'(rxOverflow), 32'h1);
    readRx("R9 older word kept");
    void'(rxExpQ.pop_front());
    check(rxOverflow, "R9 overflow sticky", 32'(rxOverflow), 32'h1);
    clrOvf = 1'b1; @(negedge clk); clrOvf = 1'b0;
    check(!rxOverflow, "R9 overflow cleared", 32'(rxOverflow), 32'h0);
    clrIrq = 1'b1; @(negedge clk); clrIrq = 1'b0;

    // abort mid-word
    setup(1'b0, 1'b0, 2'd1, 9'd3);
    i = wordIdx;
    writeWord(32'h0000_ABCD, 1);
    while (!(pulses == 3 && sck == 1'b0)) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sck == 1'b0 && txEmpty && !txFull && !rxFull && !doneIrq,
          "R10 disable stops and clears",
          {27'b0, sck, txEmpty, txFull, rxFull, doneIrq}, 32'h8);
    wrData = 32'h5555; wrEn = 1'b1; @(negedge clk); wrEn = 1'b0;
    check(txEmpty, "R10 write ignored while disabled", 32'(txEmpty), 32'h1);
    void'(expQ.pop_front());
    pulses = 0; mosiCap = '0;
    enable = 1'b1;
    repeat (100) @(negedge clk);
    check(wordIdx == i && pulses == 0 && sck == 1'b0, "R10 no resume after enable",
          32'(pulses), 32'h0);

    // slowest clock, select 3 = 32 bits, idle high, trailing change
    setup(1'b1, 1'b1, 2'd3, 9'd511);
    writeWord(32'hC001_D00D, 1);
    readRx("R1 R2 rx 32-bit word at divisor 511");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule